// File: doc/BRIEF.md
# Dual Byte-Strobe DRAM Cycle Decoder

This block is the control front end on the device side of an extended-data-out DRAM. It watches the five asynchronous control pins (row strobe, upper and lower column strobes, write enable, output enable). All five are active low. A fast internal clock samples them. The block turns their relative ordering into internal strobes: a row-address latch, a column-address latch, a write-data latch and a refresh request, plus an output-driver enable for each byte lane. The memory array and the sense timing live elsewhere and act on these strobes.

The two byte strobes merge into one internal column strobe. Each byte strobe still gates its own output lane. When a RAS cycle ends, the block reports what kind of cycle it was as a one-hot code with a single-cycle valid pulse. The possible kinds are read, early write, late write, read-modify-write, RAS-only refresh, CAS-before-RAS refresh and hidden refresh. For refreshes that take their row from the device, the block keeps an internal row counter and presents the row to refresh alongside the request.

Top module: `edo_cmd_decoder`

## Requirements
- R1: The internal column strobe is asserted while either byte strobe is low and is released only when both are high. A second byte strobe that falls while the other is still low does not produce another column latch. A new column latch needs both strobes high first and then one of them low again.
- R2: If the merged column strobe is already asserted when the row strobe falls, the cycle is a counter refresh. The block raises `refresh_req` for one cycle with `refresh_row` equal to the internal counter, raises no `row_latch` and no `col_latch`, and never drives a byte lane in that cycle.
- R3: Every counter refresh (CAS-before-RAS or hidden) advances the internal row counter by one. The counter starts at 0 after reset and wraps from 2^ROW_W-1 to 0.
- R4: If the row strobe falls with both byte strobes high and they stay high until it rises, the block gives one `row_latch` pulse and no `col_latch`, and reports a RAS-only refresh. No byte lane is driven.
- R5: If write enable is already low when the first column strobe of a row cycle asserts, the cycle is an early write. `wdata_latch` pulses together with `col_latch`, and no byte lane is driven for the whole cycle, even with output enable low.
- R6: If write enable falls after the column strobe while no read data has been driven in the cycle, the cycle is a late write, and `wdata_latch` pulses on that falling edge.
- R7: If write enable falls after read data has been driven in the cycle, the cycle is a read-modify-write. The lanes stop driving and `wdata_latch` pulses on that falling edge.
- R8: If the row strobe rises and falls again while a column strobe stays low after an access, the second row cycle is a hidden refresh (R2, R3 apply). Read data stays driven through it, and lanes release once both the row strobe and that lane's strobe are high.
- R9: A byte lane starts driving only during a read access, while the row strobe, output enable and that lane's own strobe are low and write enable is high. Bit 0 of `byte_drive` follows the lower strobe and bit 1 the upper.
- R10: A driving lane stays on after its strobe rises while the row strobe and output enable stay low. It turns off when output enable goes high, when write enable goes low, or when the row strobe and that lane's strobe are both high.
- R11: Each row-strobe rise that ends a decoded cycle gives exactly one `cycle_valid` pulse, within four clock edges of the pin change. `cycle_code` is one-hot: bit 0 read, bit 1 early write, bit 2 late write, bit 3 read-modify-write, bit 4 RAS-only refresh, bit 5 CAS-before-RAS refresh, bit 6 hidden refresh.
- R12: In page mode, each new assertion of the merged column strobe within one row cycle gives one `col_latch`. Where write enable is low at that moment it also gives one `wdata_latch`, and the class of the row cycle is set by its first column access.
- R13: After reset every strobe output, `byte_drive`, `cycle_valid`, `cycle_code` and `refresh_row` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| row_strobe_n | input | 1 | Row strobe pin, active low, asynchronous |
| col_strobe_up_n | input | 1 | Upper byte column strobe pin, active low |
| col_strobe_lo_n | input | 1 | Lower byte column strobe pin, active low |
| wr_en_n | input | 1 | Write enable pin, active low |
| out_en_n | input | 1 | Output enable pin, active low |
| row_latch | output | 1 | One-cycle pulse: capture the row address |
| col_latch | output | 1 | One-cycle pulse: capture the column address |
| wdata_latch | output | 1 | One-cycle pulse: capture the write data |
| refresh_req | output | 1 | One-cycle pulse: refresh the row on refresh_row |
| refresh_row | output | ROW_W | Row chosen by the internal refresh counter |
| byte_drive | output | 2 | Output driver enable per byte lane (bit 1 upper) |
| cycle_code | output | 7 | One-hot class of the cycle just ended |
| cycle_valid | output | 1 | One-cycle pulse marking cycle_code valid |

## Verification
The hardest state to reach is a hidden refresh with data still driven. To get there, a read must be driving a lane, then the row strobe must rise and fall again while that lane's strobe never leaves low. The block must also tell it apart from a plain CAS-before-RAS refresh, which reaches the same pin levels from idle. The bench builds this sequence for each byte mask, checks the lanes right after the second row-strobe fall, and checks the counter row against a model. Read-modify-write and late write differ only in whether a lane drove before write enable fell, so both are swept against both byte masks with output enable chosen to force each outcome.

// File: rtl/edo_dec_pkg.sv
package edo_dec_pkg;
  localparam int NUM_BYTES = 2;
  localparam int NUM_CYC   = 7;

  typedef enum logic [NUM_CYC-1:0] {
    CYC_NONE = 7'b0000000,
    CYC_READ = 7'b0000001,
    CYC_EWR  = 7'b0000010,
    CYC_LWR  = 7'b0000100,
    CYC_RMW  = 7'b0001000,
    CYC_ROR  = 7'b0010000,
    CYC_CBR  = 7'b0100000,
    CYC_HID  = 7'b1000000
  } cyc_code_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ROW,
    ST_ACC,
    ST_REF
  } dec_state_t;

  // asserted-high pin levels after inversion
  typedef struct packed {
    logic                 ras;
    logic [NUM_BYTES-1:0] bcas;   // bit 1 upper, bit 0 lower
    logic                 we;
    logic                 oe;
  } pin_lvl_t;

  // synchronized levels plus detected edges
  typedef struct packed {
    logic                 ras;
    logic                 cas_any;
    logic                 cas_prev;
    logic                 ras_fall;  // pin went low (asserted)
    logic                 ras_rise;  // pin went high (released)
    logic                 cas_fall;
    logic                 we_fall;
    logic                 we;
    logic                 oe;
    logic [NUM_BYTES-1:0] bcas;
  } pin_evt_t;
endpackage

// File: rtl/edo_pin_sync.sv
module edo_pin_sync #(
  parameter int WIDTH  = 5,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= async_in;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/edo_strobe_merge.sv
module edo_strobe_merge
  import edo_dec_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  pin_lvl_t lvl,
  output pin_evt_t ev
);
  logic ras_q, cas_q, we_q;
  logic cas_any_w;

  assign cas_any_w = |lvl.bcas;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_q <= 1'b0;
      cas_q <= 1'b0;
      we_q  <= 1'b0;
    end else begin
      ras_q <= lvl.ras;
      cas_q <= cas_any_w;
      we_q  <= lvl.we;
    end
  end

  always_comb begin
    ev.ras      = lvl.ras;
    ev.cas_any  = cas_any_w;
    ev.cas_prev = cas_q;
    ev.ras_fall = lvl.ras & ~ras_q;
    ev.ras_rise = ~lvl.ras & ras_q;
    ev.cas_fall = cas_any_w & ~cas_q;
    ev.we_fall  = lvl.we & ~we_q;
    ev.we       = lvl.we;
    ev.oe       = lvl.oe;
    ev.bcas     = lvl.bcas;
  end
endmodule

// File: rtl/edo_byte_drive.sv
module edo_byte_drive
  import edo_dec_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  pin_evt_t             ev,
  input  logic                 read_phase,
  output logic [NUM_BYTES-1:0] drv
);
  generate
    for (genvar b = 0; b < NUM_BYTES; b++) begin : g_lane
      logic set_c, clr_c;
      assign set_c = read_phase && ev.ras && ev.oe && !ev.we && ev.bcas[b];
      assign clr_c = !ev.oe || ev.we || (!ev.ras && !ev.bcas[b]);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      drv[b] <= 1'b0;
        else if (clr_c)  drv[b] <= 1'b0;
        else if (set_c)  drv[b] <= 1'b1;
      end

      // R9: a lane only drives after output enable low and write enable high
      a_r9_drive_needs_oe: assert property (@(posedge clk) disable iff (!rst_n)
        drv[b] |-> ($past(ev.oe) && !$past(ev.we)));
      // R10: row strobe and lane strobe both released turns the lane off
      a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
        (!ev.ras && !ev.bcas[b]) |=> !drv[b]);
    end
  endgenerate
endmodule

// File: rtl/edo_cycle_classifier.sv
module edo_cycle_classifier
  import edo_dec_pkg::*;
#(
  parameter int ROW_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  pin_evt_t         ev,
  input  logic             any_drive,
  output logic             row_latch,
  output logic             col_latch,
  output logic             wdata_latch,
  output logic             refresh_req,
  output logic [ROW_W-1:0] refresh_row,
  output cyc_code_t        cycle_code,
  output logic             cycle_valid,
  output logic             read_phase
);
  dec_state_t       st;
  cyc_code_t        cls;
  logic             hidden_q;
  logic             hold_q;
  logic             drove_q;
  logic [ROW_W-1:0] ctr;

  assign read_phase = (st == ST_ACC) && (cls == CYC_READ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      cls         <= CYC_NONE;
      hidden_q    <= 1'b0;
      hold_q      <= 1'b0;
      drove_q     <= 1'b0;
      ctr         <= '0;
      row_latch   <= 1'b0;
      col_latch   <= 1'b0;
      wdata_latch <= 1'b0;
      refresh_req <= 1'b0;
      refresh_row <= '0;
      cycle_code  <= CYC_NONE;
      cycle_valid <= 1'b0;
    end else begin
      row_latch   <= 1'b0;
      col_latch   <= 1'b0;
      wdata_latch <= 1'b0;
      refresh_req <= 1'b0;
      cycle_valid <= 1'b0;
      if (!ev.cas_any) hold_q <= 1'b0;

      unique case (st)
        ST_IDLE: begin
          if (ev.ras_fall) begin
            if (ev.cas_prev) begin
              refresh_req <= 1'b1;
              refresh_row <= ctr;
              ctr         <= ctr + 1'b1;
              hidden_q    <= hold_q;
              st          <= ST_REF;
            end else begin
              row_latch <= 1'b1;
              drove_q   <= 1'b0;
              st        <= ST_ROW;
            end
          end
        end
        ST_ROW: begin
          if (ev.ras_rise) begin
            cycle_valid <= 1'b1;
            cycle_code  <= CYC_ROR;
            st          <= ST_IDLE;
          end else if (ev.cas_any) begin
            col_latch <= 1'b1;
            st        <= ST_ACC;
            if (ev.we) begin
              cls         <= CYC_EWR;
              wdata_latch <= 1'b1;
            end else begin
              cls <= CYC_READ;
            end
          end
        end
        ST_ACC: begin
          if (ev.ras_rise) begin
            cycle_valid <= 1'b1;
            cycle_code  <= cls;
            st          <= ST_IDLE;
            if (ev.cas_any) hold_q <= 1'b1;
          end else begin
            if (any_drive) drove_q <= 1'b1;
            if (ev.cas_fall) begin
              col_latch <= 1'b1;
              if (ev.we) wdata_latch <= 1'b1;
            end else if (ev.we_fall && ev.cas_any) begin
              wdata_latch <= 1'b1;
              if (cls == CYC_READ) cls <= drove_q ? CYC_RMW : CYC_LWR;
            end
          end
        end
        ST_REF: begin
          if (ev.ras_rise) begin
            cycle_valid <= 1'b1;
            cycle_code  <= hidden_q ? CYC_HID : CYC_CBR;
            st          <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R11: the report is a single-cycle pulse carrying a one-hot code
  a_r11_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_valid |=> !cycle_valid);
  a_r11_code_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_valid |-> $onehot(cycle_code));
  // R2: a counter refresh never opens a row from the address pins
  a_r2_no_row_on_refresh: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_req |-> (!row_latch && !col_latch));
  // R3: the counter moves only with a refresh request
  a_r3_counter_moves_on_refresh: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctr) |-> refresh_req);
endmodule

// File: rtl/edo_cmd_decoder.sv
module edo_cmd_decoder
  import edo_dec_pkg::*;
#(
  parameter int ROW_W     = 10,
  parameter int SYNC_DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             row_strobe_n,
  input  logic             col_strobe_up_n,
  input  logic             col_strobe_lo_n,
  input  logic             wr_en_n,
  input  logic             out_en_n,
  output logic             row_latch,
  output logic             col_latch,
  output logic             wdata_latch,
  output logic             refresh_req,
  output logic [ROW_W-1:0] refresh_row,
  output logic [1:0]       byte_drive,
  output logic [6:0]       cycle_code,
  output logic             cycle_valid
);
  localparam int LVL_W = $bits(pin_lvl_t);

  pin_lvl_t         raw_lvl, sync_lvl;
  logic [LVL_W-1:0] sync_vec;
  pin_evt_t         ev;
  logic             read_phase;
  logic [NUM_BYTES-1:0] drv;
  cyc_code_t        code_w;

  always_comb begin
    raw_lvl.ras  = ~row_strobe_n;
    raw_lvl.bcas = {~col_strobe_up_n, ~col_strobe_lo_n};
    raw_lvl.we   = ~wr_en_n;
    raw_lvl.oe   = ~out_en_n;
  end

  edo_pin_sync #(.WIDTH(LVL_W), .STAGES(SYNC_DEPTH)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (raw_lvl),
    .sync_out (sync_vec)
  );

  assign sync_lvl = pin_lvl_t'(sync_vec);

  edo_strobe_merge u_merge (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl   (sync_lvl),
    .ev    (ev)
  );

  edo_cycle_classifier #(.ROW_W(ROW_W)) u_class (
    .clk         (clk),
    .rst_n       (rst_n),
    .ev          (ev),
    .any_drive   (|drv),
    .row_latch   (row_latch),
    .col_latch   (col_latch),
    .wdata_latch (wdata_latch),
    .refresh_req (refresh_req),
    .refresh_row (refresh_row),
    .cycle_code  (code_w),
    .cycle_valid (cycle_valid),
    .read_phase  (read_phase)
  );

  edo_byte_drive u_drive (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev         (ev),
    .read_phase (read_phase),
    .drv        (drv)
  );

  assign byte_drive = drv;
  assign cycle_code = code_w;

  // R5, R7: data is never captured while a lane is driving
  a_r5_no_drive_at_capture: assert property (@(posedge clk) disable iff (!rst_n)
    wdata_latch |-> (byte_drive == 2'b00));
  // R2: no lane starts driving on a refresh request
  a_r2_quiet_on_refresh: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_req && $past(byte_drive) == 2'b00) |-> (byte_drive == 2'b00));
endmodule

// File: tb/edo_cmd_decoder_bench.sv
module edo_cmd_decoder_bench;
  localparam int RW = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n;
  logic ras_n, up_n, lo_n, we_n, oe_n;
  logic row_latch, col_latch, wdata_latch, refresh_req, cycle_valid;
  logic [RW-1:0] refresh_row;
  logic [1:0] byte_drive;
  logic [6:0] cycle_code;

  edo_cmd_decoder #(.ROW_W(RW)) u_edo_cmd_decoder (
    .clk(clk), .rst_n(rst_n),
    .row_strobe_n(ras_n), .col_strobe_up_n(up_n), .col_strobe_lo_n(lo_n),
    .wr_en_n(we_n), .out_en_n(oe_n),
    .row_latch(row_latch), .col_latch(col_latch), .wdata_latch(wdata_latch),
    .refresh_req(refresh_req), .refresh_row(refresh_row),
    .byte_drive(byte_drive), .cycle_code(cycle_code), .cycle_valid(cycle_valid)
  );

  // event monitor
  int n_row = 0, n_col = 0, n_wd = 0, n_ref = 0, n_val = 0;
  logic [6:0] last_code = '0;
  logic [RW-1:0] last_ref = '0;
  always @(posedge clk) begin
    if (rst_n) begin
      if (row_latch)   n_row <= n_row + 1;
      if (col_latch)   n_col <= n_col + 1;
      if (wdata_latch) n_wd  <= n_wd + 1;
      if (refresh_req) begin n_ref <= n_ref + 1; last_ref <= refresh_row; end
      if (cycle_valid) begin n_val <= n_val + 1; last_code <= cycle_code; end
    end
  end

  int checks = 0, errors = 0;
  bit done = 0;
  int b_row, b_col, b_wd, b_ref, b_val;
  logic [RW-1:0] exp_ctr = '0;

  localparam logic [6:0] K_READ = 7'd1, K_EWR = 7'd2, K_LWR = 7'd4, K_RMW = 7'd8,
                         K_ROR = 7'd16, K_CBR = 7'd32, K_HID = 7'd64;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pins(input logic r, input logic [1:0] cas_lo_active, input logic w, input logic o);
    @(negedge clk);
    ras_n = r; up_n = ~cas_lo_active[1]; lo_n = ~cas_lo_active[0]; we_n = w; oe_n = o;
    repeat (5) @(negedge clk);
  endtask

  task automatic snap;
    b_row = n_row; b_col = n_col; b_wd = n_wd; b_ref = n_ref; b_val = n_val;
  endtask

  task automatic read_cyc(input logic [1:0] m, input bit oe);
    logic [1:0] exp_d;
    exp_d = oe ? m : 2'b00;
    snap;
    pins(1, 2'b00, 1, ~oe);
    pins(0, 2'b00, 1, ~oe);
    pins(0, m, 1, ~oe);
    chk("R9 lane drive during read", byte_drive, exp_d);
    pins(0, 2'b00, 1, ~oe);
    chk("R10 lane held after strobe rise", byte_drive, exp_d);
    pins(1, 2'b00, 1, ~oe);
    chk("R10 lane released", byte_drive, 0);
    chk("R11 read code", last_code, K_READ);
    chk("R11 one valid", n_val - b_val, 1);
    chk("R12 one column", n_col - b_col, 1);
    pins(1, 2'b00, 1, 1);
  endtask

  task automatic ewr_cyc(input logic [1:0] m);
    snap;
    pins(1, 2'b00, 0, 0);
    pins(0, 2'b00, 0, 0);
    pins(0, m, 0, 0);
    chk("R5 data latched", n_wd - b_wd, 1);
    pins(0, m, 1, 0);
    chk("R5 no drive after we rise", byte_drive, 0);
    pins(0, 2'b00, 1, 0);
    pins(1, 2'b00, 1, 1);
    chk("R5 early write code", last_code, K_EWR);
  endtask

  task automatic lwr_cyc(input logic [1:0] m);
    snap;
    pins(0, 2'b00, 1, 1);
    pins(0, m, 1, 1);
    chk("R6 no capture before we", n_wd - b_wd, 0);
    pins(0, m, 0, 1);
    chk("R6 capture on we fall", n_wd - b_wd, 1);
    pins(0, 2'b00, 1, 1);
    pins(1, 2'b00, 1, 1);
    chk("R6 late write code", last_code, K_LWR);
  endtask

  task automatic rmw_cyc(input logic [1:0] m);
    snap;
    pins(1, 2'b00, 1, 0);
    pins(0, 2'b00, 1, 0);
    pins(0, m, 1, 0);
    chk("R7 read data driven", byte_drive, m);
    pins(0, m, 0, 0);
    chk("R7 lanes off on write", byte_drive, 0);
    chk("R7 capture on we fall", n_wd - b_wd, 1);
    pins(0, 2'b00, 1, 1);
    pins(1, 2'b00, 1, 1);
    chk("R7 rmw code", last_code, K_RMW);
  endtask

  task automatic ror_cyc;
    snap;
    pins(0, 2'b00, 1, 0);
    chk("R4 no drive", byte_drive, 0);
    pins(1, 2'b00, 1, 1);
    chk("R4 one row latch", n_row - b_row, 1);
    chk("R4 no column", n_col - b_col, 0);
    chk("R4 no refresh req", n_ref - b_ref, 0);
    chk("R4 ras-only code", last_code, K_ROR);
  endtask

  task automatic cbr_cyc(input logic [1:0] m);
    snap;
    pins(1, m, 1, 0);
    pins(0, m, 1, 0);
    chk("R2 refresh req", n_ref - b_ref, 1);
    chk("R3 counter row", last_ref, exp_ctr);
    chk("R2 no row latch", n_row - b_row, 0);
    chk("R2 no drive", byte_drive, 0);
    exp_ctr = exp_ctr + 1'b1;
    pins(0, 2'b00, 1, 0);
    pins(1, 2'b00, 1, 1);
    chk("R2 cbr code", last_code, K_CBR);
    chk("R2 no column", n_col - b_col, 0);
  endtask

  task automatic hid_cyc(input logic [1:0] m);
    snap;
    pins(1, 2'b00, 1, 0);
    pins(0, 2'b00, 1, 0);
    pins(0, m, 1, 0);
    pins(1, m, 1, 0);
    chk("R8 access reported as read", last_code, K_READ);
    chk("R8 drive held over ras high", byte_drive, m);
    pins(0, m, 1, 0);
    chk("R8 refresh req", n_ref - b_ref, 1);
    chk("R8 counter row", last_ref, exp_ctr);
    exp_ctr = exp_ctr + 1'b1;
    chk("R8 drive held in refresh", byte_drive, m);
    pins(1, m, 1, 0);
    chk("R8 hidden code", last_code, K_HID);
    pins(1, 2'b00, 1, 0);
    chk("R8 release after strobes high", byte_drive, 0);
    pins(1, 2'b00, 1, 1);
  endtask

  initial begin
    rst_n = 0; ras_n = 1; up_n = 1; lo_n = 1; we_n = 1; oe_n = 1;
    repeat (5) @(negedge clk);
    chk("R13 reset strobes", {row_latch, col_latch, wdata_latch, refresh_req, cycle_valid}, 0);
    chk("R13 reset drive", byte_drive, 0);
    chk("R13 reset code", cycle_code, 0);
    chk("R13 reset row", refresh_row, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);

    for (int m = 1; m < 4; m++)
      for (int o = 0; o < 2; o++) read_cyc(m[1:0], o[0]);
    for (int m = 1; m < 4; m++) begin
      ewr_cyc(m[1:0]);
      lwr_cyc(m[1:0]);
      rmw_cyc(m[1:0]);
      hid_cyc(m[1:0]);
    end
    ror_cyc();
    // R3: run the counter past its wrap
    for (int k = 0; k < 10; k++) cbr_cyc(((k % 3) + 1));

    // R1, R12: overlapping byte strobes merge; page mode columns
    snap;
    pins(0, 2'b00, 1, 1);
    pins(0, 2'b01, 1, 1);
    pins(0, 2'b11, 1, 1);
    pins(0, 2'b10, 1, 1);
    chk("R1 overlap gives one column", n_col - b_col, 1);
    pins(0, 2'b00, 1, 1);
    pins(0, 2'b10, 1, 1);
    chk("R12 second page column", n_col - b_col, 2);
    pins(0, 2'b00, 0, 1);
    pins(0, 2'b11, 0, 1);
    chk("R12 page write column", n_col - b_col, 3);
    chk("R12 page write capture", n_wd - b_wd, 1);
    pins(0, 2'b00, 1, 1);
    pins(1, 2'b00, 1, 1);
    chk("R12 class from first access", last_code, K_READ);
    chk("R11 one valid for page cycle", n_val - b_val, 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule